// File: doc/BRIEF.md
# Local-History Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken, and it bases the guess on that branch's own recent run of outcomes. The caller gives a branch address slice, which is the word-aligned branch address with the byte-offset bits already dropped. The low part of that slice picks one of a small set of history registers. Each history register holds the most recent outcomes of the branches that map to it. The whole address slice is XORed with the selected history, and the result picks one two-bit saturating counter. The top bit of that counter is the predicted direction.

The predict port is purely combinational: an address goes in and a direction comes out in the same cycle. The update port is sampled on the clock edge. It carries a branch address and its resolved outcome. On that edge the counter chosen by the current history is trained, and the history register then takes the outcome as its newest bit. A prediction and an update in the same cycle do not interfere, because the prediction always reads the state from before the edge.

Top module: `lhbp_predictor`

## Requirements
- R1: After a synchronous active-low reset, every history register holds 0 and every counter holds 1, so every address is predicted not-taken.
- R2: The history register is selected by bits [5:0] of the address slice (64 registers), and each register is 10 bits wide.
- R3: The counter is selected by address bits [9:0] XORed bitwise with the selected 10-bit history (1024 counters).
- R4: An accepted update shifts the selected history left by one, puts the outcome (1 = taken) into bit 0, and drops the old bit 9.
- R5: An accepted update increments the counter on taken and decrements it on not-taken. The counter used is the one indexed with the history as it was before that same update.
- R6: A counter at 3 stays at 3 on taken, and a counter at 0 stays at 0 on not-taken.
- R7: The prediction is taken (1) exactly when the selected counter is 2 or 3.
- R8: A prediction made in the same cycle as an update touching the same history or counter reflects the state before that update.
- R9: When upd_valid is low, the update address and outcome have no effect on any later prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_addr | input | 10 | Branch address slice to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_addr | input | 10 | Branch address slice of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The assertions assume that pred_addr, upd_addr, upd_valid and upd_taken are driven to known values in every cycle after reset. Some of them also assume that a correlation between consecutive cycles comes only from the caller reusing an address or an index. The stimulus drives all inputs on the falling edge from a small pool of branch addresses with per-address outcome bias. This makes counters and histories repeat often enough for both saturation ends to be reached. Directed runs of identical outcomes force a history to all zeros or all ones, which pins a single counter so that its saturation can be exercised.

// File: rtl/lhbp_pkg.sv
// Package: lhbp_pkg
// Shared defaults and the direction encoding for the local-history
// branch predictor. Assumes the counter width is at least 2 bits.
package lhbp_pkg;

    // Default geometry of the predictor.
    localparam int unsigned LHBP_HIST_W   = 10;  // history bits = address slice bits
    localparam int unsigned LHBP_HIDX_W   = 6;   // bits selecting a history register
    localparam int unsigned LHBP_CTR_W    = 2;   // saturating counter width
    localparam int unsigned LHBP_CTR_INIT = 1;   // counter value after reset

    // Encoding of a branch outcome.
    typedef enum logic {
        DIR_NOT_TAKEN = 1'b0,
        DIR_TAKEN     = 1'b1
    } lhbp_dir_e;

endpackage

// File: rtl/lhbp_hist_table.sv
// Module: lhbp_hist_table
// First-level table of per-branch outcome histories. It has two
// combinational read ports (one for prediction, one for update) and one
// shift-in write port. Assumes the write index is stable at the clock edge.
// Reset clears every history to zero.
module lhbp_hist_table #(
    parameter int unsigned HIDX_W = lhbp_pkg::LHBP_HIDX_W,
    parameter int unsigned HIST_W = lhbp_pkg::LHBP_HIST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIDX_W-1:0] rd_a_idx,
    output logic [HIST_W-1:0] rd_a_hist,
    input  logic [HIDX_W-1:0] rd_b_idx,
    output logic [HIST_W-1:0] rd_b_hist,
    input  logic              wr_en,
    input  logic [HIDX_W-1:0] wr_idx,
    input  lhbp_pkg::lhbp_dir_e wr_dir
);

    localparam int unsigned ENTRIES = 1 << HIDX_W;

    logic [HIST_W-1:0] hist_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Clear on reset; otherwise shift in the outcome when this entry is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hist_q[g] <= '0;
            end else if (wr_en && (wr_idx == HIDX_W'(g))) begin
                hist_q[g] <= {hist_q[g][HIST_W-2:0], wr_dir == lhbp_pkg::DIR_TAKEN};
            end
        end
    end

    // Prediction-side read.
    always_comb rd_a_hist = hist_q[rd_a_idx];

    // Update-side read.
    always_comb rd_b_hist = hist_q[rd_b_idx];

endmodule

// File: rtl/lhbp_ctr_table.sv
// Module: lhbp_ctr_table
// Second-level table of saturating direction counters. It has two
// combinational read ports and one training write port. Assumes
// CTR_W >= 2 and CTR_INIT < 2**CTR_W. Reset loads CTR_INIT into every counter.
module lhbp_ctr_table #(
    parameter int unsigned CIDX_W   = lhbp_pkg::LHBP_HIST_W,
    parameter int unsigned CTR_W    = lhbp_pkg::LHBP_CTR_W,
    parameter int unsigned CTR_INIT = lhbp_pkg::LHBP_CTR_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CIDX_W-1:0] rd_a_idx,
    output logic [CTR_W-1:0]  rd_a_ctr,
    input  logic [CIDX_W-1:0] rd_b_idx,
    output logic [CTR_W-1:0]  rd_b_ctr,
    input  logic              wr_en,
    input  logic [CIDX_W-1:0] wr_idx,
    input  lhbp_pkg::lhbp_dir_e wr_dir
);

    localparam int unsigned         ENTRIES = 1 << CIDX_W;
    localparam logic [CTR_W-1:0]    CTR_MAX = '1;
    localparam logic [CTR_W-1:0]    CTR_RST = CTR_W'(CTR_INIT);

    logic [CTR_W-1:0] ctr_q [ENTRIES];
    logic [CTR_W-1:0] ctr_next;

    // Saturating step of the counter being trained.
    always_comb begin
        ctr_next = rd_b_ctr;
        if (wr_dir == lhbp_pkg::DIR_TAKEN) begin
            if (rd_b_ctr != CTR_MAX) ctr_next = rd_b_ctr + 1'b1;
        end else begin
            if (rd_b_ctr != '0) ctr_next = rd_b_ctr - 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        // Load the reset value, or take the trained value when this counter is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_q[g] <= CTR_RST;
            end else if (wr_en && (wr_idx == CIDX_W'(g))) begin
                ctr_q[g] <= ctr_next;
            end
        end
    end

    // Prediction-side read.
    always_comb rd_a_ctr = ctr_q[rd_a_idx];

    // Update-side read; also the base value for training.
    always_comb rd_b_ctr = ctr_q[rd_b_idx];

    logic unused_wr_idx_match;
    // The write index must equal the update read index; the top ties both together.
    always_comb unused_wr_idx_match = (wr_idx == rd_b_idx);

endmodule

// File: rtl/lhbp_predictor.sv
// Module: lhbp_predictor
// Top of the local-history two-level branch direction predictor.
// The prediction is combinational from pred_addr. An update trains the
// counter selected with the old history, and on the same edge shifts the
// outcome into that history. Assumes the caller passes the word-aligned
// branch address slice with its byte-offset bits removed.
module lhbp_predictor #(
    parameter int unsigned HIST_W   = lhbp_pkg::LHBP_HIST_W,
    parameter int unsigned HIDX_W   = lhbp_pkg::LHBP_HIDX_W,
    parameter int unsigned CTR_W    = lhbp_pkg::LHBP_CTR_W,
    parameter int unsigned CTR_INIT = lhbp_pkg::LHBP_CTR_INIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HIST_W-1:0] pred_addr,
    output logic              pred_taken,
    input  logic              upd_valid,
    input  logic [HIST_W-1:0] upd_addr,
    input  logic              upd_taken
);

    localparam int unsigned CIDX_W = HIST_W;

    logic [HIDX_W-1:0] pred_hidx, upd_hidx;
    logic [HIST_W-1:0] pred_hist, upd_hist;
    logic [CIDX_W-1:0] pred_cidx, upd_cidx;
    logic [CTR_W-1:0]  pred_ctr, upd_ctr;
    lhbp_pkg::lhbp_dir_e upd_dir;

    // First-level selection from the low address bits.
    always_comb begin
        pred_hidx = pred_addr[HIDX_W-1:0];
        upd_hidx  = upd_addr[HIDX_W-1:0];
    end

    // Outcome encoding for the tables.
    always_comb upd_dir = upd_taken ? lhbp_pkg::DIR_TAKEN : lhbp_pkg::DIR_NOT_TAKEN;

    lhbp_hist_table #(
        .HIDX_W (HIDX_W),
        .HIST_W (HIST_W)
    ) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (pred_hidx),
        .rd_a_hist (pred_hist),
        .rd_b_idx  (upd_hidx),
        .rd_b_hist (upd_hist),
        .wr_en     (upd_valid),
        .wr_idx    (upd_hidx),
        .wr_dir    (upd_dir)
    );

    // Second-level selection: address XOR local history.
    always_comb begin
        pred_cidx = pred_addr ^ pred_hist;
        upd_cidx  = upd_addr ^ upd_hist;
    end

    lhbp_ctr_table #(
        .CIDX_W   (CIDX_W),
        .CTR_W    (CTR_W),
        .CTR_INIT (CTR_INIT)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (pred_cidx),
        .rd_a_ctr (pred_ctr),
        .rd_b_idx (upd_cidx),
        .rd_b_ctr (upd_ctr),
        .wr_en    (upd_valid),
        .wr_idx   (upd_cidx),
        .wr_dir   (upd_dir)
    );

    // Taken when the counter sits in its upper half.
    always_comb pred_taken = pred_ctr[CTR_W-1];

endmodule

// File: rtl/lhbp_predictor_chk.sv
// Module: lhbp_predictor_chk
// Checker for lhbp_predictor, attached by bind. It watches the table read
// values that the top routes between its sub-blocks. Assumes all inputs
// are known after reset.
module lhbp_predictor_chk #(
    parameter int unsigned HIST_W   = 10,
    parameter int unsigned HIDX_W   = 6,
    parameter int unsigned CTR_W    = 2,
    parameter int unsigned CTR_INIT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_valid,
    input logic              upd_taken,
    input logic [HIDX_W-1:0] pred_hidx,
    input logic [HIDX_W-1:0] upd_hidx,
    input logic [HIST_W-1:0] pred_hist,
    input logic [HIST_W-1:0] upd_hist,
    input logic [HIST_W-1:0] pred_cidx,
    input logic [HIST_W-1:0] upd_cidx,
    input logic [CTR_W-1:0]  pred_ctr,
    input logic [CTR_W-1:0]  upd_ctr,
    input logic              pred_taken
);

    localparam logic [CTR_W-1:0] CMAX = '1;

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pred_hist == '0) && (pred_ctr == CTR_W'(CTR_INIT)) && !pred_taken); // R1

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid) && (pred_hidx == $past(upd_hidx)))
        |-> pred_hist == {$past(upd_hist[HIST_W-2:0]), $past(upd_taken)}); // R4

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(upd_valid) && (pred_hidx == $past(pred_hidx)))
        |-> pred_hist == $past(pred_hist)); // R9

    AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && upd_taken && (upd_ctr != CMAX))
         && (pred_cidx == $past(upd_cidx)))
        |-> pred_ctr == $past(upd_ctr) + 1'b1); // R5

    AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && !upd_taken && (upd_ctr != '0))
         && (pred_cidx == $past(upd_cidx)))
        |-> pred_ctr == $past(upd_ctr) - 1'b1); // R5

    AST_CTR_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && upd_taken && (upd_ctr == CMAX))
         && (pred_cidx == $past(upd_cidx)))
        |-> pred_ctr == CMAX); // R6

    AST_CTR_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && !upd_taken && (upd_ctr == '0))
         && (pred_cidx == $past(upd_cidx)))
        |-> pred_ctr == '0); // R6

    AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(pred_taken)); // R7

endmodule

bind lhbp_predictor lhbp_predictor_chk #(
    .HIST_W   (HIST_W),
    .HIDX_W   (HIDX_W),
    .CTR_W    (CTR_W),
    .CTR_INIT (CTR_INIT)
) u_lhbp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .pred_hidx  (pred_hidx),
    .upd_hidx   (upd_hidx),
    .pred_hist  (pred_hist),
    .upd_hist   (upd_hist),
    .pred_cidx  (pred_cidx),
    .upd_cidx   (upd_cidx),
    .pred_ctr   (pred_ctr),
    .upd_ctr    (upd_ctr),
    .pred_taken (pred_taken)
);

// File: tb/lhbp_predictor_bench.sv
// Bench for lhbp_predictor: seeded random traffic plus directed corner
// runs, checked every cycle against a reference model made of bench functions.
module lhbp_predictor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HW = 10;
    localparam int HX = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] pred_addr = '0;
    logic          pred_taken;
    logic          upd_valid = 1'b0;
    logic [HW-1:0] upd_addr = '0;
    logic          upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [HW-1:0] m_hist [64];
    logic [1:0]    m_ctr  [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    lhbp_predictor u_lhbp_predictor (
        .clk        (clk),
        .rst_n      (rst_n),
        .pred_addr  (pred_addr),
        .pred_taken (pred_taken),
        .upd_valid  (upd_valid),
        .upd_addr   (upd_addr),
        .upd_taken  (upd_taken)
    );

    // Model: counter index from the address slice and its history (R2, R3).
    function automatic logic [HW-1:0] m_cidx(input logic [HW-1:0] a);
        return a ^ m_hist[a[HX-1:0]];
    endfunction

    // Model: predicted direction (R7).
    function automatic logic m_pred(input logic [HW-1:0] a);
        return m_ctr[m_cidx(a)] >= 2'd2;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 64; i++) m_hist[i] = '0;
        for (int i = 0; i < 1024; i++) m_ctr[i] = 2'd1;
    endfunction

    // Model: train with the old history (R5, R6), then shift the history (R4).
    function automatic void m_update(input logic [HW-1:0] a, input logic t);
        logic [HW-1:0] ci;
        ci = m_cidx(a);
        if (t && m_ctr[ci] != 2'd3) m_ctr[ci] = m_ctr[ci] + 2'd1;
        if (!t && m_ctr[ci] != 2'd0) m_ctr[ci] = m_ctr[ci] - 2'd1;
        m_hist[a[HX-1:0]] = {m_hist[a[HX-1:0]][HW-2:0], t};
    endfunction

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d got=%0b exp=%0b", req, pred_addr, got, exp);
        end
    endtask

    // One cycle: drive on the falling edge, compare before the rising edge, advance the model at the edge.
    task automatic step(input logic [HW-1:0] pa, input logic uv,
                        input logic [HW-1:0] ua, input logic ut, input string req);
        @(negedge clk);
        pred_addr = pa; upd_valid = uv; upd_addr = ua; upd_taken = ut;
        #2;
        check(pred_taken, m_pred(pa), req);
        @(posedge clk);
        if (uv) m_update(ua, ut);
    endtask

    initial begin
        logic [HW-1:0] pool [8];
        logic [7:0]    bias [8];
        void'($urandom(32'h1F2E3D4C));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: everything predicts not-taken after reset.
        for (int i = 0; i < 16; i++) step(HW'(i * 67), 1'b0, '0, 1'b0, "R1");

        // R6 bottom: history stays 0, same counter goes 1 -> 0 -> 0.
        for (int i = 0; i < 4; i++) step(HW'(5), 1'b1, HW'(5), 1'b0, "R6");
        // R5/R4: ten takens drive the history to all ones, then the counter climbs and saturates (R6 top).
        for (int i = 0; i < 16; i++) step(HW'(5), 1'b1, HW'(5), 1'b1, "R5");
        for (int i = 0; i < 4; i++) step(HW'(5), 1'b0, HW'(5), 1'b0, "R6");
        // R8: predict and update the same address in the same cycle; prediction sees the old state.
        for (int i = 0; i < 8; i++) step(HW'(9), 1'b1, HW'(9), 1'b1, "R8");
        // R2/R3: addresses that share history bits [5:0] but differ in bits [9:6].
        for (int i = 0; i < 8; i++) step(HW'(9 + 64 * i), 1'b1, HW'(9 + 64 * (i % 3)), i[0], "R3");
        // R9: junk on the update port with upd_valid low changes nothing.
        for (int i = 0; i < 12; i++) step(HW'(9), 1'b0, HW'(9), 1'b0, "R9");
        for (int i = 0; i < 12; i++) step(HW'(5), 1'b0, HW'(5), 1'b1, "R9");

        // Random traffic over a small pool with per-address bias (R2, R3, R4, R5, R7).
        for (int i = 0; i < 8; i++) begin
            pool[i] = HW'($urandom);
            bias[i] = 8'($urandom);
        end
        for (int n = 0; n < 4000; n++) begin
            int p, u;
            p = int'($urandom % 8);
            u = int'($urandom % 8);
            step(pool[p], ($urandom % 8) != 0, pool[u],
                 8'($urandom) < bias[u], "R7");
        end

        // Mid-run reset returns to the reset state (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_reset();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step(pool[i], 1'b0, '0, 1'b0, "R1");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule